// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is a synchronous up-counter stage, four bits wide by default. It holds a registered count that changes only on the rising clock edge, apart from the clear. Each edge applies one of four operations, in fixed priority: clear to zero, parallel load from the data input, increment, or hold. The clear and the load strobes are active low. A parameter sets whether the clear takes effect at once or at the next clock edge.

Two active-high enables must both be high for the stage to count. The trickle enable also gates the terminal-count flag, which is high when the count is all ones. Stages chain by driving every parallel enable from the system enable and each trickle enable from the previous stage's terminal count. The result behaves as one wide counter. With the synchronous clear, a decode of a chosen count fed back into the clear shortens the count cycle.

Top module: `bin_counter_stage`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `tc_o` is 0.
- R2: With `CLR_SYNC` = 0, a low `clr_ni` forces `count_o` to 0 at once, before any clock edge, whatever the load and enable levels.
- R3: With `CLR_SYNC` = 1, a low `clr_ni` leaves `count_o` unchanged until the next rising edge and makes it 0 at that edge, whatever the load and enable levels.
- R4: With `clr_ni` high and `load_ni` low, the rising edge copies `data_i` into `count_o`, whatever the levels of `en_par_i` and `en_trk_i`.
- R5: With `clr_ni` and `load_ni` high and both `en_par_i` and `en_trk_i` high, the rising edge increments `count_o` by one.
- R6: With `clr_ni` and `load_ni` high and either enable low, `count_o` keeps its value across the edge.
- R7: `tc_o` is high exactly when `en_trk_i` is high and `count_o` is all ones, without waiting for a clock edge; `en_par_i` has no effect on it.
- R8: Incrementing from all ones wraps `count_o` to 0.
- R9: Four chained stages count as one 16-bit counter under the system enable. Stage 0 takes both enables from the system enable. Each later stage takes its trickle enable from the previous `tc_o` and its parallel enable from the system enable. Stage k holds bits 4k+3 to 4k.
- R10: With `CLR_SYNC` = 1, both enables high, and `clr_ni` driven low when the count equals 6, the count repeats 0, 1, …, 6, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Clear to zero, active low; timing set by `CLR_SYNC` |
| load_ni | input | 1 | Parallel load strobe, active low |
| data_i | input | WIDTH | Value taken on load |
| en_par_i | input | 1 | Parallel count enable, active high |
| en_trk_i | input | 1 | Trickle count enable, active high; also gates `tc_o` |
| count_o | output | WIDTH | Registered count |
| tc_o | output | 1 | Terminal count: trickle enable and count all ones |

## Verification
Load, increment, hold and the synchronous clear take effect one edge after the inputs are set. The bench sets the inputs on the falling edge and samples 1 ns after the next rising edge. The asynchronous clear and the terminal-count flag need no edge, so the bench samples them half a nanosecond after driving, still before the edge. At that point the synchronous stage must still show its old count. The chained and modulus-7 checks follow the same one-edge rule, and their expected values come from arithmetic models in the bench.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;
endpackage

// File: rtl/bcs_mode_sel.sv
module bcs_mode_sel
  import bcs_pkg::*;
#(
  parameter bit CLR_SYNC = 1'b0
) (
  input  logic clr_ni,
  input  logic load_ni,
  input  logic en_par_i,
  input  logic en_trk_i,
  output op_e  op_o
);
  // the asynchronous variant clears in the flop, not through the next-state path
  always_comb begin
    if (CLR_SYNC && !clr_ni)       op_o = OP_CLEAR;
    else if (!load_ni)             op_o = OP_LOAD;
    else if (en_par_i && en_trk_i) op_o = OP_COUNT;
    else                           op_o = OP_HOLD;
  end
endmodule

// File: rtl/bcs_next.sv
module bcs_next
  import bcs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  op_e              op_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_CLEAR: cnt_o = '0;
      OP_LOAD:  cnt_o = data_i;
      OP_COUNT: cnt_o = cnt_i + One;
      default:  cnt_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/bcs_tc_dec.sv
module bcs_tc_dec #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             en_trk_i,
  output logic             tc_o
);
  assign tc_o = en_trk_i & (&cnt_i);
endmodule

// File: rtl/bin_counter_stage.sv
module bin_counter_stage
  import bcs_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit CLR_SYNC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [WIDTH-1:0] AllOnes = {WIDTH{1'b1}};

  op_e              op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  bcs_mode_sel #(.CLR_SYNC(CLR_SYNC)) u_mode (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_par_i(en_par_i),
    .en_trk_i(en_trk_i),
    .op_o    (op)
  );

  bcs_next #(.WIDTH(WIDTH)) u_next (
    .op_i  (op),
    .cnt_i (cnt_q),
    .data_i(data_i),
    .cnt_o (cnt_d)
  );

  bcs_tc_dec #(.WIDTH(WIDTH)) u_tc (
    .cnt_i   (cnt_q),
    .en_trk_i(en_trk_i),
    .tc_o    (tc_o)
  );

  generate
    if (CLR_SYNC) begin : g_sync_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      a_r3_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |=> (count_o == '0));
    end else begin : g_async_clr
      always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!clr_ni) cnt_q <= '0;
        else              cnt_q <= cnt_d;
      end

      a_r2_async_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |-> (count_o == '0));
    end
  endgenerate

  assign count_o = cnt_q;

  a_r4_load_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (!clr_ni || count_o == $past(data_i)));

  a_r5_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_par_i && en_trk_i)
      |=> (!clr_ni || count_o == $past(count_o) + WIDTH'(1)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(en_par_i && en_trk_i)) |=> (!clr_ni || $stable(count_o)));

  a_r7_tc_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (en_trk_i && count_o == AllOnes));
endmodule

// File: tb/bin_counter_stage_test.sv
`timescale 1ns/1ps
module bin_counter_stage_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1, load_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] din = '0;

  logic [3:0] q_s, q_a;
  logic       tc_s, tc_a;

  // main sweep: synchronous-clear stage (uut) and asynchronous-clear stage
  bin_counter_stage #(.WIDTH(4), .CLR_SYNC(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n), .data_i(din),
    .en_par_i(ep), .en_trk_i(et), .count_o(q_s), .tc_o(tc_s));

  bin_counter_stage #(.WIDTH(4), .CLR_SYNC(1'b0)) uut_async (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n), .data_i(din),
    .en_par_i(ep), .en_trk_i(et), .count_o(q_a), .tc_o(tc_a));

  // four-stage chain
  logic        ch_load_n = 1'b1, ch_en = 1'b0;
  logic [15:0] ch_data = '0;
  logic [3:0]  ch_q [4];
  logic        ch_tc [4];
  for (genvar k = 0; k < 4; k++) begin : g_chain
    logic trk;
    if (k == 0) begin : g_first
      assign trk = ch_en;
    end else begin : g_rest
      assign trk = ch_tc[k-1];
    end
    bin_counter_stage #(.WIDTH(4), .CLR_SYNC(1'b1)) u_st (
      .clk_i(clk), .rst_ni(rst_n), .clr_ni(1'b1), .load_ni(ch_load_n),
      .data_i(ch_data[4*k +: 4]), .en_par_i(ch_en), .en_trk_i(trk),
      .count_o(ch_q[k]), .tc_o(ch_tc[k]));
  end
  wire [15:0] ch_val = {ch_q[3], ch_q[2], ch_q[1], ch_q[0]};

  // modulus-7 stage: clear fed from a decode of 6
  logic [3:0] q_m;
  logic       tc_m;
  wire        m_clr_n = ~(q_m == 4'd6);
  bin_counter_stage #(.WIDTH(4), .CLR_SYNC(1'b1)) u_mod7 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(m_clr_n), .load_ni(1'b1), .data_i(4'd0),
    .en_par_i(1'b1), .en_trk_i(1'b1), .count_o(q_m), .tc_o(tc_m));

  int m_exp;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_exp <= 0;
    else        m_exp <= (m_exp == 6) ? 0 : m_exp + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int next_val(input int cur, input bit c, input bit l,
                                  input bit p, input bit t, input int d);
    if (!c)          return 0;
    else if (!l)     return d;
    else if (p && t) return (cur + 1) % 16;
    else             return cur;
  endfunction

  function automatic string req_of(input bit c, input bit l, input bit p, input bit t,
                                   input int cur);
    if (!c)          return "R3";
    else if (!l)     return "R4";
    else if (p && t) return (cur == 15) ? "R8" : "R5";
    else             return "R6";
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    clr_n = 1'b1; load_n = 1'b0; din = 4'hF; ep = 1'b1; et = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sync count", q_s, 0);
    chk("R1 async count", q_a, 0);
    chk("R1 tc", tc_s, 0);
    chk("R1 chain", ch_val, 0);
    @(negedge clk);
    load_n = 1'b1; ep = 1'b0; et = 1'b0;
    rst_n = 1'b1;

    // near-exhaustive sweep: every start value against every control pattern
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        bit cc, ll, pp, tt;
        int d, es, ea;
        cc = c[3]; ll = c[2]; pp = c[1]; tt = c[0];
        @(negedge clk);
        clr_n = 1'b1; load_n = 1'b0; din = 4'(s); ep = 1'b0; et = 1'b0;
        @(posedge clk); #1;
        chk("R4 preload", q_s, s);
        @(negedge clk);
        d = s ^ 4'hA;
        clr_n = cc; load_n = ll; ep = pp; et = tt; din = 4'(d);
        #0.5;
        chk("R3 before edge", q_s, s);
        chk("R2 immediate", q_a, cc ? s : 0);
        chk("R7 tc", tc_s, (tt && s == 15) ? 1 : 0);
        chk("R7 tc async", tc_a, (tt && cc && s == 15) ? 1 : 0);
        es = next_val(s, cc, ll, pp, tt, d);
        ea = next_val(cc ? s : 0, cc, ll, pp, tt, d);
        @(posedge clk); #1;
        chk(req_of(cc, ll, pp, tt, s), q_s, es);
        chk(cc ? req_of(cc, ll, pp, tt, s) : "R2", q_a, ea);
      end
    end

    // R9: four-stage chain across low and high wraps with a gapped enable
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1; ep = 1'b0; et = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      int ch_exp;
      ch_exp = (pass == 0) ? 16'hFFF0 : 16'h0FFD;
      @(negedge clk);
      ch_load_n = 1'b0; ch_data = 16'(ch_exp); ch_en = 1'b1;
      @(posedge clk); #1;
      chk("R9 chain load", ch_val, ch_exp);
      for (int i = 0; i < 40; i++) begin
        bit en;
        en = (i % 5) != 2;
        @(negedge clk);
        ch_load_n = 1'b1; ch_en = en;
        #0.5;
        chk("R9 chain top tc", ch_tc[3], (en && ch_exp == 16'hFFFF) ? 1 : 0);
        if (en) ch_exp = (ch_exp + 1) % 65536;
        @(posedge clk); #1;
        chk("R9 chain value", ch_val, ch_exp);
      end
    end

    // R10: shortened cycle from a decode of 6
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R10 mod7", q_m, m_exp);
      chk("R10 range", (q_m <= 4'd6) ? 1 : 0, 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule